// File: doc/BRIEF.md
# Selectable-Source Gated Clock Divider

This block produces an auxiliary clock for one peripheral. A multiplexer takes one of six incoming source clocks. An integer divider then divides that source by a programmed ratio, and an enable gates the result. The ratio is given as an 8-bit code and equals the code plus one, so it runs from 1 to 256. A status output reports whether the generated clock is currently running. This lets a peripheral get a finer baud or sampling clock than its bus clock can give.

The enable is taken into the selected source domain through a synchronizer. Starting and stopping happen only on source edges, and a stop always waits for the current output period to finish. Every pulse on the output therefore has its full width, including the first and the last. The divide code is latched only while the block is idle. The source select has to be held steady by the user while the clock runs.

Top module: `gck_gen`

## Requirements
- R1: While `rst_ni` is low, and after reset until `en_i` is raised, `gclk_o` and `on_o` are low.
- R2: With `sel_i` = k for k in 0..5, the output is derived from `src_clk_i[k]`: its period is (code+1) times that source's period.
- R3: With divide code c on `div_code_i`, the output period is (c+1) selected-source periods, for every c from 0 to 255.
- R4: For a ratio N of 2 or more, `gclk_o` is high for floor(N/2) source periods starting at a source rising edge and low for the rest. For N = 1, `gclk_o` equals the selected source while running.
- R5: `en_i` passes through a two-stage synchronizer clocked by the selected source. `on_o` rises at the third source rising edge after `en_i` rises. For N of 2 or more, `gclk_o` rises at that same edge.
- R6: Every high pulse on `gclk_o` has the width given by R4, including the first pulse after enable and the last pulse before stop.
- R7: A change of `div_code_i` while `on_o` is high has no effect on the running output. The new code takes effect at the next enable.
- R8: With `sel_i` = 6 or 7, no source is selected: `gclk_o` and `on_o` stay low even with `en_i` high.
- R9: After `en_i` falls, the current output period completes, then `on_o` falls and `gclk_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | 6 | Source clocks; bit k is source k |
| sel_i | input | 3 | Source index; 6 and 7 select nothing |
| div_code_i | input | 8 | Divide code; ratio is code+1 |
| en_i | input | 1 | Output enable, asynchronous to the sources |
| gclk_o | output | 1 | Generated, gated clock |
| on_o | output | 1 | High while the generated clock is running |

## Verification
The assertions assume that `sel_i` holds still for as long as `on_o` is high. They also assume that the divide code reaches the latch while the block is idle, so the latched code never moves during a run. The bench keeps to this by setting the select and code only while enable is low and `on_o` has already fallen. It changes the code on a running clock only in the one case that R7 tests. A pulse-width monitor checks every high pulse against the width expected from the configuration in force.

// File: rtl/gck_pkg.sv
package gck_pkg;
   localparam int unsigned GCK_NUM_SRC     = 6;
   localparam int unsigned GCK_DIV_W       = 8;
   localparam int unsigned GCK_SYNC_STAGES = 2;
endpackage

// File: rtl/gck_src_mux.sv
module gck_src_mux #(
   parameter int unsigned NUM_SRC = 6,
   parameter int unsigned SEL_W   = 3
) (
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic               mclk_o
);
   logic [NUM_SRC-1:0] hit;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
      assign hit[i] = src_i[i] & (sel_i == SEL_W'(i));
   end

   assign mclk_o = |hit;
endmodule

// File: rtl/gck_en_sync.sv
module gck_en_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= '0;
         else         chain_q <= d_i;
      end
   end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= '0;
         else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gck_divider.sv
module gck_divider #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_s_i,
   input  logic [DIV_W-1:0] code_i,
   output logic             gclk_o,
   output logic             on_o,
   output logic [DIV_W-1:0] cnt_o,
   output logic [DIV_W-1:0] dcode_o
);
   localparam int unsigned HW = DIV_W + 1;

   logic [DIV_W-1:0] dcode_q, cnt_q, pos_n;
   logic [HW-1:0]    half;
   logic             act_q, hi_q, gate_q, wrap, bypass;

   assign half   = ({1'b0, dcode_q} + HW'(1)) >> 1;
   assign wrap   = (cnt_q == dcode_q);
   assign pos_n  = wrap ? '0 : cnt_q + DIV_W'(1);
   assign bypass = (dcode_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q   <= 1'b0;
         cnt_q   <= '0;
         dcode_q <= '0;
         hi_q    <= 1'b0;
      end else if (act_q) begin
         if (wrap && !en_s_i) begin
            act_q <= 1'b0;
            cnt_q <= '0;
            hi_q  <= 1'b0;
         end else begin
            cnt_q <= pos_n;
            hi_q  <= ({1'b0, pos_n} < half);
         end
      end else if (en_s_i) begin
         act_q <= 1'b1;
         cnt_q <= '0;
         hi_q  <= (half != '0);
      end else begin
         dcode_q <= code_i;
         cnt_q   <= '0;
         hi_q    <= 1'b0;
      end
   end

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gate_q <= 1'b0;
      else         gate_q <= act_q;
   end

   assign gclk_o  = bypass ? (clk_i & gate_q) : hi_q;
   assign on_o    = act_q;
   assign cnt_o   = cnt_q;
   assign dcode_o = dcode_q;
endmodule

// File: rtl/gck_gen.sv
module gck_gen #(
   parameter int unsigned NUM_SRC     = gck_pkg::GCK_NUM_SRC,
   parameter int unsigned DIV_W       = gck_pkg::GCK_DIV_W,
   parameter int unsigned SYNC_STAGES = gck_pkg::GCK_SYNC_STAGES,
   localparam int unsigned SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC + 1) : 1
) (
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_clk_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [DIV_W-1:0]   div_code_i,
   input  logic               en_i,
   output logic               gclk_o,
   output logic               on_o
);
   initial begin
      assert (NUM_SRC >= 1 && NUM_SRC < (1 << SEL_W))
         else $error("gck_gen: NUM_SRC out of range");
      assert (DIV_W >= 1 && DIV_W <= 16)
         else $error("gck_gen: DIV_W out of range");
      assert (SYNC_STAGES >= 2)
         else $error("gck_gen: SYNC_STAGES must be at least 2");
   end

   logic             mclk;
   logic             en_s;
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] dcode;

   gck_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
      .src_i  (src_clk_i),
      .sel_i  (sel_i),
      .mclk_o (mclk)
   );

   gck_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (mclk),
      .rst_ni (rst_ni),
      .d_i    (en_i),
      .q_o    (en_s)
   );

   gck_divider #(.DIV_W(DIV_W)) u_div (
      .clk_i   (mclk),
      .rst_ni  (rst_ni),
      .en_s_i  (en_s),
      .code_i  (div_code_i),
      .gclk_o  (gclk_o),
      .on_o    (on_o),
      .cnt_o   (cnt),
      .dcode_o (dcode)
   );
endmodule

// File: rtl/gck_gen_chk.sv
module gck_gen_chk #(
   parameter int unsigned DIV_W = 8,
   parameter int unsigned SEL_W = 3
) (
   input logic             mclk,
   input logic             rst_ni,
   input logic             en_s,
   input logic             on_o,
   input logic             gclk_o,
   input logic [SEL_W-1:0] sel_i,
   input logic [DIV_W-1:0] cnt,
   input logic [DIV_W-1:0] dcode
);
   p_start_sync_r5: assert property (@(posedge mclk) disable iff (!rst_ni)
      $rose(on_o) |-> $past(en_s));

   p_stop_at_end_r9: assert property (@(posedge mclk) disable iff (!rst_ni)
      $fell(on_o) |-> $past(cnt == dcode));

   p_code_hold_r7: assert property (@(posedge mclk) disable iff (!rst_ni)
      (on_o && $past(on_o)) |-> $stable(dcode));

   p_cnt_range_r3: assert property (@(posedge mclk) disable iff (!rst_ni)
      cnt <= dcode);

   p_idle_low_r1: assert property (@(posedge mclk) disable iff (!rst_ni)
      (!on_o && !$past(on_o)) |-> !gclk_o);

   p_sel_hold_r2: assert property (@(posedge mclk) disable iff (!rst_ni)
      (on_o && $past(on_o)) |-> $stable(sel_i));
endmodule

bind gck_gen gck_gen_chk #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_chk (
   .mclk   (mclk),
   .rst_ni (rst_ni),
   .en_s   (en_s),
   .on_o   (on_o),
   .gclk_o (gclk_o),
   .sel_i  (sel_i),
   .cnt    (cnt),
   .dcode  (dcode)
);

// File: tb/gck_gen_tb_top.sv
`timescale 1ns/1ps
module gck_gen_tb_top;
   logic s0 = 0, s1 = 0, s2 = 0, s3 = 0, s4 = 0, s5 = 0;
   logic [5:0] src;
   logic       rst_ni = 0;
   logic [2:0] sel = 0;
   logic [7:0] code = 0;
   logic       en = 0;
   logic       gclk, on;

   always #2.5 s0 = ~s0;   // 200 MHz, source 0
   always #3.0 s1 = ~s1;
   always #4.0 s2 = ~s2;
   always #5.0 s3 = ~s3;
   always #6.0 s4 = ~s4;
   always #7.0 s5 = ~s5;
   assign src = {s5, s4, s3, s2, s1, s0};

   gck_gen dut_i (
      .rst_ni(rst_ni), .src_clk_i(src), .sel_i(sel), .div_code_i(code),
      .en_i(en), .gclk_o(gclk), .on_o(on)
   );

   int  n_tests = 0, n_fail = 0, rises = 0;
   real t_rise = 0.0, exp_high = 0.0;
   bit  mon_on = 0;

   function automatic real tper(int s);
      case (s)
         0: return 5.0;  1: return 6.0;  2: return 8.0;
         3: return 10.0; 4: return 12.0; default: return 14.0;
      endcase
   endfunction

   task automatic chk(bit ok, string req, string what, real act, real expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, expv);
      end
   endtask

   function automatic bit near(real a, real b);
      return (a - b < 0.01) && (b - a < 0.01);
   endfunction

   always @(posedge gclk) begin
      t_rise = $realtime;
      rises++;
   end

   // R6: every high pulse has full width
   always @(negedge gclk) begin
      if (mon_on)
         chk(near($realtime - t_rise, exp_high), "R6", "pulse width",
             $realtime - t_rise, exp_high);
   end

   task automatic run_cfg(int s, int c, string req);
      real t = tper(s);
      int  n = c + 1;
      real t0, tn, t1;
      sel = 3'(s);
      code = 8'(c);
      exp_high = (n == 1) ? t / 2.0 : real'(n / 2) * t;
      #20;
      en = 1;
      @(posedge gclk); t0 = $realtime;
      @(negedge gclk); tn = $realtime;
      @(posedge gclk); t1 = $realtime;
      chk(near(t1 - t0, real'(n) * t), req, "period", t1 - t0, real'(n) * t);
      chk(near(tn - t0, exp_high), "R4", "high time", tn - t0, exp_high);
      en = 0;
      wait (!on);
      #(3.0 * t);
      chk(gclk == 0, "R9", "gclk after stop", real'(gclk), 0.0);
   endtask

   initial begin
      #900us;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      real t0, t1;
      #11;
      chk(gclk == 0 && on == 0, "R1", "outputs in reset", real'({gclk, on}), 0.0);
      #12 rst_ni = 1;
      #50;
      chk(gclk == 0 && on == 0 && rises == 0, "R1", "outputs idle after reset",
          real'(rises), 0.0);
      mon_on = 1;

      // R5: enable latency through synchronizer, source 0, ratio 4
      sel = 0; code = 3; exp_high = 10.0;
      #20;
      @(negedge s0); en = 1;
      @(posedge s0); @(posedge s0); #1;
      chk(on == 0, "R5", "on after 2 edges", real'(on), 0.0);
      @(posedge s0); #1;
      chk(on == 1 && gclk == 1, "R5", "on/gclk after 3 edges", real'({on, gclk}), 3.0);
      en = 0;
      wait (!on);
      #20;

      // R3 / R4: sweep on source 0
      for (int c = 0; c < 64; c++) run_cfg(0, c, "R3");
      run_cfg(0, 127, "R3");
      run_cfg(0, 128, "R3");
      run_cfg(0, 254, "R3");
      run_cfg(0, 255, "R3");

      // R2: every other source
      for (int s = 1; s < 6; s++) begin
         run_cfg(s, 0, "R2");
         run_cfg(s, 1, "R2");
         run_cfg(s, 2, "R2");
         run_cfg(s, 6, "R2");
         run_cfg(s, 200, "R2");
      end

      // R7: code change while running is ignored until next enable
      sel = 0; code = 3; exp_high = 10.0;
      #20;
      en = 1;
      @(posedge gclk);
      code = 9;
      @(posedge gclk); t0 = $realtime;
      @(posedge gclk); t1 = $realtime;
      chk(near(t1 - t0, 20.0), "R7", "period while code changed", t1 - t0, 20.0);
      en = 0;
      wait (!on);
      #20;
      exp_high = 25.0;
      en = 1;
      @(posedge gclk); t0 = $realtime;
      @(posedge gclk); t1 = $realtime;
      chk(near(t1 - t0, 50.0), "R7", "period after re-enable", t1 - t0, 50.0);
      en = 0;
      wait (!on);
      #20;

      // R8: out-of-range select
      for (int s = 6; s < 8; s++) begin
         int r0;
         sel = 3'(s); code = 2;
         #20;
         r0 = rises;
         en = 1;
         #300;
         chk(on == 0 && rises == r0, "R8", "no output for empty select",
             real'(rises - r0), 0.0);
         en = 0;
         #20;
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule